// File: doc/BRIEF.md
# Data Cache Way Integrity Scanner

This block examines one set of a four-way data cache after a cache error has been signalled. Given a set index, it walks the ways in order, reading each way's tag through a one-cycle-latency array read port. It judges the tag's coherence state code and two parity groups that cover the physical tag. When data checking is requested, it also reads the line's four doublewords and checks each one against its 8-bit check byte with a 64+8 ECC.

For every way the scanner emits one result on a valid/ready stream. The result carries the way number, that way's error flags, a bad-ECC mask over its doublewords, and the physical address rebuilt from the tag and the set index. Back-pressure: while `res_valid` is high and `res_ready` is low, the result is held unchanged and the scanner issues no further reads. The next way begins only after a transfer. The flags of all ways are ORed into `err_flags`. `done` pulses for one cycle after the last way is accepted.

Flag encoding, used in both `res_flags` and `err_flags`: bit 3 is the illegal tag state, bit 2 is the tag-address parity error, bit 1 is the single-bit data error, and bit 0 is the double/multi-bit data error.

Top module: `dcc_entry_checker`

## Requirements
- R1: After reset, `busy`, `done`, `res_valid`, `rd_en` and `err_flags` are all zero.
- R2: Read addresses have the form {way[1:0], index[7:0], dword[1:0], 3'b000}, and read data returns in the cycle after `rd_en`. Each way gets one tag read at dword 0. Four data reads at dword 0 to 3 follow only when `check_data` was high at start. A full scan therefore makes 20 reads with data checking and 4 reads without it.
- R3: The state code is tag-high bits 29:25. The codes 0x00, 0x0F, 0x13, 0x16, 0x19 and 0x1C are legal. Any other code sets flag bit 3, and the parity checks for that way are skipped.
- R4: For a legal state, tag-low bit 11 must equal the XOR of tag-low bits 39:26, and tag-low bit 10 must equal the XOR of tag-low bits 25:13. A mismatch in either sets flag bit 2.
- R5: Check bit i of a doubleword is the parity of (data AND M_i), where M_i is 64'h0738C808099264FF rotated left by 8*i bits. A syndrome (computed XOR stored) of weight one sets flag bit 1. Any other nonzero syndrome sets flag bit 0.
- R6: A doubleword at offset k with a nonzero syndrome sets bit (3-k) of `res_bad_ecc`. The mask is zero when data checking is off.
- R7: `res_pa` = {tag-low bits 39:13, set index, 5'b00000}.
- R8: Exactly one result per way is produced, in way order 0 to 3, on a valid/ready stream. A pending result stays stable until it is accepted.
- R9: `err_flags` is cleared at start and holds the OR of all way flags. `done` is a one-cycle pulse in the cycle after the last result transfer, and `busy` is low from then on.
- R10: `start` is ignored while a scan is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (sampled only when idle) |
| set_idx | input | IDX_W | Set index to scan |
| check_data | input | 1 | Also check the data doublewords |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flags | output | 4 | Flags accumulated over all ways |
| rd_en | output | 1 | Array read request |
| rd_addr | output | ADDR_W | Array read address |
| rd_tag_hi | input | 32 | High tag word, one cycle after rd_en |
| rd_tag_lo | input | 64 | Low tag word, one cycle after rd_en |
| rd_dword | input | 64 | Data doubleword, one cycle after rd_en |
| rd_ecc | input | 8 | Stored check byte, one cycle after rd_en |
| res_valid | output | 1 | Way result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_way | output | WAY_W | Way the result belongs to |
| res_flags | output | 4 | Flags of this way |
| res_bad_ecc | output | LINE_DW | Per-doubleword bad-ECC mask |
| res_pa | output | PA_W | Reconstructed physical address |

## Verification
Several properties are checked on every cycle. A stalled result must not change, and a result may appear only during a scan. `done` must be a single cycle, must follow a transfer, and must coincide with idle. Reads must be spaced and aligned. An illegal-state way must never also report a parity error. A nonzero bad-ECC mask must appear exactly when a data flag is set. Only the bench scenarios can show that the state table, the two parity groups, the rotated ECC masks, the syndrome weight classes, the mask bit order, the address rebuild, the read counts and the way ordering give the right values. They do so by comparing with array contents built from known injected faults, with and without stalls, with data checking off, and with a start pulse arriving mid-scan.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int FLG_W     = 4;
  localparam int FLG_STATE = 3;
  localparam int FLG_ADDR  = 2;
  localparam int FLG_SBE   = 1;
  localparam int FLG_DBE   = 0;

  localparam int STATE_LSB  = 25;
  localparam int STATE_W    = 5;
  localparam int PAR_HI_BIT = 11;
  localparam int PAR_LO_BIT = 10;
  localparam int PTAG_SPLIT = 26;

  localparam logic [63:0] ECC_BASE = 64'h0738C808099264FF;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_TAG_RD, SQ_TAG_EV, SQ_DAT_RD, SQ_DAT_EV, SQ_EMIT
  } scan_state_e;

  // mask of check bit i: base pattern rotated left by one byte per bit
  function automatic logic [63:0] ecc_mask(input int unsigned bit_i);
    logic [127:0] t;
    t = {ECC_BASE, ECC_BASE} << (8 * bit_i);
    return t[127:64];
  endfunction

  function automatic logic state_legal(input logic [STATE_W-1:0] s);
    case (s)
      5'h00, 5'h0F, 5'h13, 5'h16, 5'h19, 5'h1C: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dcc_tag_chk.sv
module dcc_tag_chk
  import dcc_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int IDX_LSB = 5,
  parameter int PA_W    = 40
) (
  input  logic [31:0]      tag_hi,
  input  logic [63:0]      tag_lo,
  input  logic [IDX_W-1:0] idx,
  output logic             state_bad,
  output logic             addr_bad,
  output logic [PA_W-1:0]  pa
);
  localparam int PTAG_LSB = IDX_LSB + IDX_W;

  logic legal, hi_grp_bad, lo_grp_bad;

  always_comb begin
    legal      = state_legal(tag_hi[STATE_LSB +: STATE_W]);
    hi_grp_bad = tag_lo[PAR_HI_BIT] ^ (^tag_lo[PA_W-1:PTAG_SPLIT]);
    lo_grp_bad = tag_lo[PAR_LO_BIT] ^ (^tag_lo[PTAG_SPLIT-1:PTAG_LSB]);
    state_bad  = ~legal;
    addr_bad   = legal & (hi_grp_bad | lo_grp_bad);
    pa         = {tag_lo[PA_W-1:PTAG_LSB], idx, {IDX_LSB{1'b0}}};
  end

  logic unused_tag_bits;
  assign unused_tag_bits = ^{tag_hi[31:30], tag_hi[24:0], tag_lo[63:PA_W],
                             tag_lo[PTAG_LSB-1:12], tag_lo[9:0]};
endmodule

// File: rtl/dcc_ecc_chk.sv
module dcc_ecc_chk
  import dcc_pkg::*;
(
  input  logic [63:0] dword,
  input  logic [7:0]  stored,
  output logic        sbe,
  output logic        dbe
);
  logic [7:0] calc;
  logic [7:0] syn;
  logic [3:0] weight;

  for (genvar i = 0; i < 8; i++) begin : g_chk
    localparam logic [63:0] MASK = ecc_mask(i);
    assign calc[i] = ^(dword & MASK);
  end

  always_comb begin
    syn    = calc ^ stored;
    weight = 4'($countones(syn));
    sbe    = (weight == 4'd1);
    dbe    = (|syn) & (weight != 4'd1);
  end
endmodule

// File: rtl/dcc_scan_seq.sv
module dcc_scan_seq
  import dcc_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int LINE_DW  = 4,
  parameter int IDX_W    = 8,
  parameter int PA_W     = 40,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int OFF_W   = $clog2(LINE_DW),
  localparam int ADDR_W  = WAY_W + IDX_W + OFF_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               check_data,
  input  logic               tag_state_bad,
  input  logic               tag_addr_bad,
  input  logic [PA_W-1:0]    tag_pa,
  input  logic               dw_sbe,
  input  logic               dw_dbe,
  output logic [IDX_W-1:0]   idx_q,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               busy,
  output logic               done,
  output logic [FLG_W-1:0]   err_flags,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [WAY_W-1:0]   res_way,
  output logic [FLG_W-1:0]   res_flags,
  output logic [LINE_DW-1:0] res_bad_ecc,
  output logic [PA_W-1:0]    res_pa
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(LINE_DW - 1);

  scan_state_e         st_q;
  logic [WAY_W-1:0]    way_q;
  logic [OFF_W-1:0]    off_q;
  logic                data_q;
  logic                done_q;
  logic [FLG_W-1:0]    acc_q;
  logic [FLG_W-1:0]    wflg_q;
  logic [LINE_DW-1:0]  wmask_q;
  logic [PA_W-1:0]     wpa_q;

  logic [FLG_W-1:0]    tag_flg, dat_flg;
  logic [LINE_DW-1:0]  off_bit;
  logic [OFF_W-1:0]    addr_off;

  always_comb begin
    tag_flg            = '0;
    tag_flg[FLG_STATE] = tag_state_bad;
    tag_flg[FLG_ADDR]  = tag_addr_bad;
    dat_flg            = '0;
    dat_flg[FLG_SBE]   = dw_sbe;
    dat_flg[FLG_DBE]   = dw_dbe;
    // offset 0 owns the most significant mask bit
    off_bit  = LINE_DW'(1) << (LAST_OFF - off_q);
    addr_off = (st_q == SQ_DAT_RD) ? off_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      way_q   <= '0;
      off_q   <= '0;
      idx_q   <= '0;
      data_q  <= 1'b0;
      done_q  <= 1'b0;
      acc_q   <= '0;
      wflg_q  <= '0;
      wmask_q <= '0;
      wpa_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (start) begin
            idx_q  <= set_idx;
            data_q <= check_data;
            acc_q  <= '0;
            way_q  <= '0;
            st_q   <= SQ_TAG_RD;
          end
        end
        SQ_TAG_RD: st_q <= SQ_TAG_EV;
        SQ_TAG_EV: begin
          wflg_q  <= tag_flg;
          wmask_q <= '0;
          wpa_q   <= tag_pa;
          acc_q   <= acc_q | tag_flg;
          off_q   <= '0;
          st_q    <= data_q ? SQ_DAT_RD : SQ_EMIT;
        end
        SQ_DAT_RD: st_q <= SQ_DAT_EV;
        SQ_DAT_EV: begin
          if (dw_sbe | dw_dbe) begin
            wmask_q <= wmask_q | off_bit;
          end
          wflg_q <= wflg_q | dat_flg;
          acc_q  <= acc_q | dat_flg;
          if (off_q == LAST_OFF) begin
            st_q <= SQ_EMIT;
          end else begin
            off_q <= off_q + 1'b1;
            st_q  <= SQ_DAT_RD;
          end
        end
        SQ_EMIT: begin
          if (res_ready) begin
            if (way_q == LAST_WAY) begin
              st_q   <= SQ_IDLE;
              done_q <= 1'b1;
            end else begin
              way_q <= way_q + 1'b1;
              st_q  <= SQ_TAG_RD;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign rd_en       = (st_q == SQ_TAG_RD) || (st_q == SQ_DAT_RD);
  assign rd_addr     = {way_q, idx_q, addr_off, 3'b000};
  assign busy        = (st_q != SQ_IDLE);
  assign done        = done_q;
  assign err_flags   = acc_q;
  assign res_valid   = (st_q == SQ_EMIT);
  assign res_way     = way_q;
  assign res_flags   = wflg_q;
  assign res_bad_ecc = wmask_q;
  assign res_pa      = wpa_q;
endmodule

// File: rtl/dcc_entry_checker.sv
module dcc_entry_checker
  import dcc_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int LINE_DW  = 4,
  parameter int IDX_W    = 8,
  parameter int PA_W     = 40,
  localparam int WAY_W   = $clog2(NUM_WAYS),
  localparam int OFF_W   = $clog2(LINE_DW),
  localparam int IDX_LSB = OFF_W + 3,
  localparam int ADDR_W  = WAY_W + IDX_W + IDX_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               check_data,
  output logic               busy,
  output logic               done,
  output logic [3:0]         err_flags,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [31:0]        rd_tag_hi,
  input  logic [63:0]        rd_tag_lo,
  input  logic [63:0]        rd_dword,
  input  logic [7:0]         rd_ecc,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [WAY_W-1:0]   res_way,
  output logic [3:0]         res_flags,
  output logic [LINE_DW-1:0] res_bad_ecc,
  output logic [PA_W-1:0]    res_pa
);
  logic [IDX_W-1:0] idx_q;
  logic             tag_state_bad, tag_addr_bad, dw_sbe, dw_dbe;
  logic [PA_W-1:0]  tag_pa;

  dcc_tag_chk #(.IDX_W(IDX_W), .IDX_LSB(IDX_LSB), .PA_W(PA_W)) u_tag (
    .tag_hi    (rd_tag_hi),
    .tag_lo    (rd_tag_lo),
    .idx       (idx_q),
    .state_bad (tag_state_bad),
    .addr_bad  (tag_addr_bad),
    .pa        (tag_pa)
  );

  dcc_ecc_chk u_ecc (
    .dword  (rd_dword),
    .stored (rd_ecc),
    .sbe    (dw_sbe),
    .dbe    (dw_dbe)
  );

  dcc_scan_seq #(.NUM_WAYS(NUM_WAYS), .LINE_DW(LINE_DW), .IDX_W(IDX_W), .PA_W(PA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .set_idx       (set_idx),
    .check_data    (check_data),
    .tag_state_bad (tag_state_bad),
    .tag_addr_bad  (tag_addr_bad),
    .tag_pa        (tag_pa),
    .dw_sbe        (dw_sbe),
    .dw_dbe        (dw_dbe),
    .idx_q         (idx_q),
    .rd_en         (rd_en),
    .rd_addr       (rd_addr),
    .busy          (busy),
    .done          (done),
    .err_flags     (err_flags),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_way       (res_way),
    .res_flags     (res_flags),
    .res_bad_ecc   (res_bad_ecc),
    .res_pa        (res_pa)
  );
endmodule

// File: rtl/dcc_entry_checker_sva.sv
module dcc_entry_checker_sva #(
  parameter int WAY_W  = 2,
  parameter int LINE_DW = 4,
  parameter int PA_W   = 40,
  parameter int ADDR_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               res_valid,
  input logic               res_ready,
  input logic [WAY_W-1:0]   res_way,
  input logic [3:0]         res_flags,
  input logic [LINE_DW-1:0] res_bad_ecc,
  input logic [PA_W-1:0]    res_pa
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_way) && $stable(res_pa)
      && $stable(res_flags) && $stable(res_bad_ecc));
  // R8
  valid_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(res_valid && res_ready));
  // R2
  read_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
  // R2
  read_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_addr[2:0] == 3'b000);
  // R3
  state_skips_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_flags[3] |-> !res_flags[2]);
  // R6
  mask_matches_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_bad_ecc != '0) == (res_flags[1] | res_flags[0])));
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(res_valid && res_ready) |=> busy);
endmodule

bind dcc_entry_checker dcc_entry_checker_sva #(
  .WAY_W(WAY_W), .LINE_DW(LINE_DW), .PA_W(PA_W), .ADDR_W(ADDR_W)
) i_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_way     (res_way),
  .res_flags   (res_flags),
  .res_bad_ecc (res_bad_ecc),
  .res_pa      (res_pa)
);

// File: tb/test_dcc_entry_checker.sv
module test_dcc_entry_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  set_idx = '0;
  logic        check_data = 1'b0;
  logic        busy, done, rd_en, res_valid;
  logic        res_ready = 1'b0;
  logic [3:0]  err_flags, res_flags, res_bad_ecc;
  logic [14:0] rd_addr;
  logic [31:0] rd_tag_hi = '0;
  logic [63:0] rd_tag_lo = '0, rd_dword = '0;
  logic [7:0]  rd_ecc = '0;
  logic [1:0]  res_way;
  logic [39:0] res_pa;

  always #5 clk = ~clk;

  dcc_entry_checker i_dcc_entry_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .set_idx(set_idx),
    .check_data(check_data), .busy(busy), .done(done), .err_flags(err_flags),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_tag_hi(rd_tag_hi), .rd_tag_lo(rd_tag_lo),
    .rd_dword(rd_dword), .rd_ecc(rd_ecc), .res_valid(res_valid), .res_ready(res_ready),
    .res_way(res_way), .res_flags(res_flags), .res_bad_ecc(res_bad_ecc), .res_pa(res_pa)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // array model: one-cycle read latency
  logic [31:0] m_hi [4];
  logic [63:0] m_lo [4];
  logic [63:0] m_d  [4][4];
  logic [7:0]  m_e  [4][4];
  logic [7:0]  cur_idx = '0;
  int          n_reads = 0, n_badaddr = 0;

  always @(posedge clk) begin
    if (rd_en) begin
      n_reads <= n_reads + 1;
      if (rd_addr[12:5] != cur_idx || rd_addr[2:0] != 3'b000) n_badaddr <= n_badaddr + 1;
      rd_tag_hi <= m_hi[rd_addr[14:13]];
      rd_tag_lo <= m_lo[rd_addr[14:13]];
      rd_dword  <= m_d[rd_addr[14:13]][rd_addr[4:3]];
      rd_ecc    <= m_e[rd_addr[14:13]][rd_addr[4:3]];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  localparam logic [63:0] BASE = 64'h0738C808099264FF;
  function automatic logic [7:0] ref_ecc(input logic [63:0] d);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      logic p = 1'b0;
      for (int b = 0; b < 64; b++)
        if (d[b] && BASE[(b + 64 - 8 * i) % 64]) p = ~p;
      r[i] = p;
    end
    return r;
  endfunction

  function automatic bit ref_legal(input logic [4:0] s);
    return s == 5'h00 || s == 5'h0F || s == 5'h13 || s == 5'h16 || s == 5'h19 || s == 5'h1C;
  endfunction

  logic [63:0] seed = 64'h9E3779B97F4A7C15;
  task automatic rnd(output logic [63:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    r = seed;
  endtask

  // vector: idx[68:61] chk[60] states[59:40] (way w at 40+5w)
  //         parity-bad[39:32] (way w at 32+2w, bit1=bit11 group, bit0=bit10 group)
  //         fault[31:0] (way w dword d at 2*(4w+d)): 0 none, 1 one check bit, 2 two, 3 all
  localparam logic [68:0] VEC [6] = '{
    {8'h00, 1'b1, {5'h0F, 5'h13, 5'h19, 5'h00}, 8'h00, 32'h0000_0000},
    {8'hFF, 1'b1, {5'h16, 5'h1C, 5'h0F, 5'h13}, 8'h00, 32'h0080_0001},
    {8'h5A, 1'b1, {5'h1F, 5'h01, 5'h13, 5'h0F}, 8'b11_01_10_00, 32'h0000_0C00},
    {8'hA5, 1'b0, {5'h13, 5'h13, 5'h13, 5'h13}, 8'b00_00_00_01, 32'hFFFF_FFFF},
    {8'h3C, 1'b1, {5'h1C, 5'h1C, 5'h1C, 5'h1C}, 8'h00, 32'h5500_AA00},
    {8'h81, 1'b1, {5'h00, 5'h12, 5'h1E, 5'h0F}, 8'h00, 32'h0000_0009}
  };

  task automatic run_scan(input logic [68:0] v, input bit stall, input bit intrude);
    logic [3:0]  ef [4];
    logic [3:0]  em [4];
    logic [39:0] ep [4];
    logic [3:0]  eacc = '0;
    logic [63:0] r;
    logic [7:0]  idx = v[68:61];
    bit          chk = v[60];
    for (int w = 0; w < 4; w++) begin
      logic [4:0] s  = v[40 + 5 * w +: 5];
      logic [1:0] pb = v[32 + 2 * w +: 2];
      rnd(r); m_hi[w] = r[31:0]; m_hi[w][29:25] = s;
      rnd(r); m_lo[w] = r;
      m_lo[w][11] = (^r[39:26]) ^ pb[1];
      m_lo[w][10] = (^r[25:13]) ^ pb[0];
      ep[w] = {r[39:13], idx, 5'b0};
      ef[w] = {~ref_legal(s), ref_legal(s) && (pb != 2'b00), 2'b00};
      em[w] = '0;
      for (int d = 0; d < 4; d++) begin
        logic [1:0] fm = v[2 * (4 * w + d) +: 2];
        rnd(r); m_d[w][d] = r;
        m_e[w][d] = ref_ecc(r) ^ (fm == 2'd1 ? 8'h04 : fm == 2'd2 ? 8'h21 :
                                  fm == 2'd3 ? 8'hFF : 8'h00);
        if (chk && fm != 2'd0) begin
          em[w][3 - d] = 1'b1;
          if (fm == 2'd1) ef[w][1] = 1'b1; else ef[w][0] = 1'b1;
        end
      end
      eacc = eacc | ef[w];
    end
    @(negedge clk);
    cur_idx = idx; n_reads = 0; n_badaddr = 0;
    start = 1'b1; set_idx = idx; check_data = chk;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
    if (intrude) begin
      @(negedge clk);
      start = 1'b1; set_idx = ~idx; check_data = ~chk;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 4; w++) begin
      while (!res_valid) @(negedge clk);
      if (stall) begin
        logic [39:0] pa0 = res_pa;
        repeat (3) @(negedge clk);
        check(res_valid && res_pa == pa0, "R8", "held under stall", 64'(res_pa), 64'(pa0));
      end
      check(res_way == 2'(w), "R8", "way order", 64'(res_way), 64'(w));
      check(res_flags[3:2] == ef[w][3:2], "R3/R4", "tag flags", 64'(res_flags), 64'(ef[w]));
      check(res_flags[1:0] == ef[w][1:0], "R5", "data flags", 64'(res_flags), 64'(ef[w]));
      check(res_bad_ecc == em[w], "R6", "bad mask", 64'(res_bad_ecc), 64'(em[w]));
      check(res_pa == ep[w], "R7", "phys addr", 64'(res_pa), 64'(ep[w]));
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
    end
    check(done == 1'b1 && busy == 1'b0, "R9", "done after last", 64'({done, busy}), 64'b10);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", 64'(done), 64'd0);
    check(err_flags == eacc, "R9", "accumulated flags", 64'(err_flags), 64'(eacc));
    check(n_reads == (chk ? 20 : 4), "R2", "read count", 64'(n_reads), 64'(chk ? 20 : 4));
    check(n_badaddr == 0, "R2", "read address form", 64'(n_badaddr), 64'd0);
    check(res_valid == 1'b0, "R8", "no fifth result", 64'(res_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({busy, done, res_valid, rd_en} == 4'b0, "R1", "control outputs", 64'({busy, done, res_valid, rd_en}), 64'd0);
    check(err_flags == 4'b0, "R1", "flags", 64'(err_flags), 64'd0);
    for (int i = 0; i < 6; i++) run_scan(VEC[i], (i % 2) == 1, 1'b0);
    // R9 flags cleared by a new clean scan after a faulty one
    run_scan(VEC[0], 1'b0, 1'b0);
    // R10 start pulse during a scan changes nothing
    run_scan(VEC[1], 1'b1, 1'b1);
    // R5 syndrome of weight 8 with data off: no flags (R6)
    run_scan({8'h07, 1'b0, {5'h0F, 5'h0F, 5'h0F, 5'h0F}, 8'h00, 32'hFFFF_FFFF}, 1'b0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule